// File: doc/BRIEF.md
# Tri-State Strap Pin Decoder

This block reads a small group of board-identification strap pins, each of which can be in one of three states: tied low externally, tied high externally, or left floating. It cannot tell a floating pin from a tied one by sampling once. So it turns on the internal pull-ups of all pins, waits for the pads to settle, and samples. It then turns on the internal pull-downs, waits again, and samples a second time. A floating pin follows whichever internal pull is on. A tied pin keeps its level whatever the pull does.

Each pin is classified from its two samples. The classifications are then folded into one identifier. Depending on a mode input, the identifier is a true base-3 number or a row of 2-bit fields. When the identifier is ready, the block drops every internal pull to save power and pulses a done strobe. Software or a boot sequencer starts a read with a one-cycle start pulse and takes the identifier when done goes high.

Top module: `strap_decoder`

## Requirements
- R1: While reset is asserted and right after it, all pull-up and pull-down enables are 0, `done` is 0 and `id_out` is 0.
- R2: A start pulse in the idle state begins a read. The first phase sets every bit of `pu_en` to 1 and every bit of `pd_en` to 0 for exactly SETTLE cycles, where SETTLE = CLK_HZ/100000 + 2. This is a 10 us settle plus two synchronizer stages.
- R3: The two phases are separated by exactly one cycle in which every pull enable is 0. No pin ever has its pull-up and pull-down enabled in the same cycle.
- R4: The second phase sets every bit of `pd_en` to 1 and every bit of `pu_en` to 0 for exactly SETTLE cycles. `done` rises 2*SETTLE+1 cycles after the clock edge that accepts start.
- R5: Each pin's code is {up XOR down, down}, taken from its pull-up sample and its pull-down sample. A pin tied low gives 0, a pin tied high gives 1, and a floating pin gives 2.
- R6: With `tern_mode`=1, the identifier is the sum of code[i]*3^(N-1-i), so pin 0 is the most significant base-3 digit. Example: N=4 with all pins floating gives 80.
- R7: With `tern_mode`=0, pin i's code sits in bits [2*(N-1-i)+1 : 2*(N-1-i)], so pin 0 occupies the top two bits of the 2N-bit field.
- R8: `done` is high for exactly one cycle per read. `id_out` changes only in the cycle `done` is high, and holds until the next read completes.
- R9: A start pulse that arrives while a read is in progress has no effect: the read ends at the same cycle with the same identifier, and no further read follows.
- R10: Once a read completes, all pull enables stay 0 until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to read the straps |
| tern_mode | input | 1 | 1: base-3 packing, 0: 2-bit field packing |
| pin_in | input | N_PINS | Raw strap pin levels (asynchronous) |
| pu_en | output | N_PINS | Per-pin internal pull-up enable |
| pd_en | output | N_PINS | Per-pin internal pull-down enable |
| id_out | output | ID_W | Decoded identifier, max(2*N_PINS, ceil(log2(3^N_PINS))) bits |
| done | output | 1 | One-cycle strobe when `id_out` is updated |

## Verification
The hardest case to reach from the ports is a floating pin, because the pin level must follow the block's own pull enables. The bench models each pad from its strap setting. A floating pad drives 1 while `pu_en` is set, 0 while `pd_en` is set, and 0 with no pull, so a wrong phase order or a missing gap changes the decoded code. A second start is injected in the middle of the pull-up phase to show it neither shifts the completion cycle nor triggers a second read.

// File: rtl/strap_decoder.sv
module strap_decoder #(
  parameter int N_PINS = 4,
  parameter int CLK_HZ = 100_000_000,
  parameter int ID_W   = (2 * N_PINS > $clog2(3 ** N_PINS)) ? 2 * N_PINS : $clog2(3 ** N_PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tern_mode,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pu_en,
  output logic [N_PINS-1:0] pd_en,
  output logic [ID_W-1:0]   id_out,
  output logic              done
);
  localparam int SYNC   = 2;
  localparam int SETTLE = CLK_HZ / 100_000 + SYNC;
  localparam int CW     = $clog2(SETTLE + 1);

  typedef enum logic [1:0] {IDLE, UP, GAP, DOWN} st_t;
  st_t st;

  logic [N_PINS-1:0] s1, s2, up_smp;
  logic [CW-1:0]     cnt;
  logic [ID_W-1:0]   fold;
  wire               settled = (cnt == CW'(SETTLE - 1));

  assign pu_en = (st == UP)   ? '1 : '0;
  assign pd_en = (st == DOWN) ? '1 : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
    end
  end

  always_comb begin
    fold = '0;
    for (int i = 0; i < N_PINS; i++) begin
      if (tern_mode) fold = fold * ID_W'(3);
      else           fold = fold << 2;
      fold = fold + ID_W'({up_smp[i] ^ s2[i], s2[i]});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      up_smp <= '0;
      id_out <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st  <= UP;
          cnt <= '0;
        end
        UP: if (settled) begin
          up_smp <= s2;
          st     <= GAP;
        end else cnt <= cnt + 1'b1;
        GAP: begin
          cnt <= '0;
          st  <= DOWN;
        end
        DOWN: if (settled) begin
          id_out <= fold;
          done   <= 1'b1;
          st     <= IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  a_r3_no_both_pulls: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en & pd_en) == '0);
  a_r3_gap_after_up: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pu_en[0]) |-> pd_en == '0);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_id_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(id_out));
  a_r10_pulls_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pu_en == '0 && pd_en == '0));
  a_r9_busy_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (st == UP && !settled) |=> st == UP);
endmodule

// File: tb/tb_strap_decoder.sv
module tb_strap_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int HZ = 400_000;
  localparam int S = HZ / 100_000 + 2;
  localparam int W = 8;

  logic clk = 0, rst_n = 0, start = 0, tern_mode = 0;
  logic [N-1:0] pin_in, pu_en, pd_en;
  logic [W-1:0] id_out;
  logic done;
  logic [1:0] strap [N];
  int errors = 0, checks = 0;

  strap_decoder #(.N_PINS(N), .CLK_HZ(HZ)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tern_mode(tern_mode),
    .pin_in(pin_in), .pu_en(pu_en), .pd_en(pd_en), .id_out(id_out), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++)
      pin_in[i] = (strap[i] == 2'd0) ? 1'b0 : (strap[i] == 2'd1) ? 1'b1 : pu_en[i];

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: expected completion, got hang");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_id(input logic t);
    int acc = 0;
    for (int i = 0; i < N; i++) acc = t ? acc * 3 + strap[i] : (acc << 2) | strap[i];
    return acc;
  endfunction

  // runs one read; optional second start injected during the pull-up phase
  task automatic run_read(input logic t, input logic [1:0] s0, s1, s2, s3,
                          input bit inject, input string tag);
    int n = 0, nup = 0, ndn = 0, ngap = 0, both = 0, ndone = 0;
    strap[0] = s0; strap[1] = s1; strap[2] = s2; strap[3] = s3;
    tern_mode = t;
    @(negedge clk); start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
    while (n < 4 * S) begin
      if (pu_en == '1 && pd_en == '0) nup++;
      else if (pd_en == '1 && pu_en == '0) ndn++;
      else if (pu_en == '0 && pd_en == '0 && nup == S && ndn == 0) ngap++;
      if ((pu_en & pd_en) != 0) both++;
      if (inject && n == 1) start = 1; else start = 0;
      @(posedge clk); n++;
      @(negedge clk);
      if (done) break;
    end
    chk({tag, " R2 pull-up cycles"}, nup, S);
    chk({tag, " R3 gap cycles"}, ngap, 1);
    chk({tag, " R3 both pulls"}, both, 0);
    chk({tag, " R4 pull-down cycles"}, ndn, S);
    chk({tag, " R4 done latency"}, n, 2 * S + 1);
    chk({tag, t ? " R6 tern id" : " R7 field id"}, id_out, expect_id(t));
    // R8/R10: single pulse, hold, pulls off
    for (int k = 0; k < 2 * S + 4; k++) begin
      @(negedge clk);
      if (done) ndone++;
      if (pu_en != 0 || pd_en != 0) both++;
    end
    chk({tag, " R8 done pulses"}, ndone, 0);
    chk({tag, " R8 id hold"}, id_out, expect_id(t));
    chk({tag, " R10 pulls off"}, both, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) strap[i] = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 pu_en", pu_en, 0);
    chk("R1 pd_en", pd_en, 0);
    chk("R1 done", done, 0);
    chk("R1 id_out", id_out, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {pu_en, pd_en, id_out, 7'b0, done}, 0);

    run_read(1'b0, 2'd0, 2'd1, 2'd2, 2'd2, 0, "field mixed");   // R5 R7: 0x1A
    run_read(1'b1, 2'd2, 2'd2, 2'd2, 2'd2, 0, "tern float");    // R6: 80
    run_read(1'b1, 2'd1, 2'd0, 2'd2, 2'd1, 0, "tern mixed");    // R5 R6: 27+6+1=34
    run_read(1'b0, 2'd2, 2'd0, 2'd0, 2'd1, 0, "field pin0");    // R7: 0x81
    run_read(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 0, "tern zero");
    run_read(1'b1, 2'd0, 2'd2, 2'd1, 2'd0, 1, "R9 restart");    // R9: 21
    chk("R6 pin0 msd literal", id_out, 21);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule